// File: doc/BRIEF.md
# Dual-Compare PWM Timer

This block is an 8-bit timer that generates a pulse-width-modulated output. A prescaler counts pulses on a clock-enable input and divides them by 2, 4, 8 or 8000. Each terminal count of the prescaler advances the timer counter by one. In PWM mode two compare registers shape the waveform. A match on the edge register drives the output pin to one programmed level. A match on the period register drives the pin to a second programmed level and reloads the counter to the start value FCh instead of zero.

Because of this reload, a period register value of N gives a period of N+5 counter steps. To get a period of t seconds at timer input frequency f, software loads t·f/divide − 5. The period match also sets a sticky status flag. That flag drives the interrupt line when it is enabled and not masked. Software clears the flag with a two-step read sequence.

Software sees the block through a byte-wide register port. Writes take effect on a clock edge. Reads are combinational from the address.

Top module: `pwm_dual_timer`

## Requirements
- R1: After reset the counter reads FCh, the configuration (address 0), edge compare (address 1), period compare (address 2) and status (address 3) all read 00h, and pwm_out and irq are 0. Writes to addresses 0 to 2 read back unchanged.
- R2: Configuration bits 7:6 select the prescaler divide: 0 gives 2, 1 gives 4, 2 gives 8 and 3 gives 8000 pulses of tick_en per counter step. The counter does not change while tick_en is low. The counter reads back at address 5.
- R3: A write that changes configuration bits 7:6 restarts the prescaler from zero. After such a write the first counter step comes exactly one full divide after the write.
- R4: With configuration bit 4 (PWM mode) set, a counter step taken while the counter equals the period compare loads FCh. A period value B therefore repeats every (B+5) steps.
- R5: In PWM mode a step at the edge compare value sets the output level to configuration bit 0. A step at the period value sets it to configuration bit 1, and the period match wins if both match. With bit 0 = 1 and bit 1 = 0 the high time is (B−A) steps. With the bits swapped, the low time is (B−A) steps.
- R6: When configuration bits 0 and 1 are equal, pwm_out stays constant once it has settled.
- R7: pwm_out is 0 whenever configuration bit 5 (output enable) is 0.
- R8: A period match sets the flag, which reads as status bit 0. irq equals flag AND configuration bit 2 (interrupt enable) AND NOT configuration bit 3 (interrupt mask).
- R9: A read of address 3 while the flag is set arms a clear, and a later read of address 4 clears the flag. A read of address 4 that is not armed leaves the flag set. If a period match occurs in the same cycle as the clearing read, the flag stays set.
- R10: With PWM mode off, the counter steps freely and wraps from FFh to 00h with no reload. The flag is not set, and the output level holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_en | input | 1 | Clock-enable pulse counted by the prescaler |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe, used for the flag-clear sequence |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| pwm_out | output | 1 | PWM output pin |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a period match that lands in the same clock as the read that completes the flag clear. This needs the prescaler phase and the counter value to be known exactly at the moment of the read. The bench stops free-running ticks and changes the clock select twice to zero the prescaler. It then feeds tick_en one pulse at a time, polling the counter until it sits on the period value with the prescaler one pulse short of terminal. At that point it issues the last tick and the clearing read in the same cycle.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int SEL_W  = 2;
  localparam int N_SEL  = 1 << SEL_W;

  localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMPA = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMPB = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd3;
  localparam logic [ADDR_W-1:0] A_CLR  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd5;

  typedef struct packed {
    logic [SEL_W-1:0] clk_sel;
    logic             out_en;
    logic             pwm_on;
    logic             irq_mask;
    logic             irq_en;
    logic             lvl_b;
    logic             lvl_a;
  } cfg_t;
endpackage

// File: rtl/pwmt_prescaler.sv
module pwmt_prescaler
  import pwmt_pkg::*;
#(
  parameter int DIV0 = 2,
  parameter int DIV1 = 4,
  parameter int DIV2 = 8,
  parameter int DIV3 = 8000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [SEL_W-1:0] sel,
  input  logic             restart,
  output logic             step
);
  localparam int DIVS [N_SEL] = '{DIV0, DIV1, DIV2, DIV3};
  localparam int MAXD01 = (DIV0 > DIV1) ? DIV0 : DIV1;
  localparam int MAXD23 = (DIV2 > DIV3) ? DIV2 : DIV3;
  localparam int MAXDIV = (MAXD01 > MAXD23) ? MAXD01 : MAXD23;
  localparam int PRE_W  = (MAXDIV > 2) ? $clog2(MAXDIV) : 1;

  logic [PRE_W-1:0] lim_tab [N_SEL];
  logic [PRE_W-1:0] lim;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic             at_end;

  for (genvar g = 0; g < N_SEL; g++) begin : g_lim
    assign lim_tab[g] = PRE_W'(DIVS[g] - 1);
  end

  assign lim    = lim_tab[sel];
  assign at_end = (pre_q == lim);
  assign step   = tick_en & at_end & ~restart;

  always_comb begin
    pre_d = pre_q;
    if (restart) begin
      pre_d = '0;
    end else if (tick_en) begin
      pre_d = at_end ? '0 : pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R2: without a tick and without a restart the prescaler does not move
  p_pre_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !restart) |=> $stable(pre_q));

  // R3: a restart always leaves the prescaler at zero
  p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pre_q == '0));
endmodule

// File: rtl/pwmt_core.sv
module pwmt_core
  import pwmt_pkg::*;
#(
  parameter logic [DATA_W-1:0] RELOAD = 8'hFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              pwm_on,
  input  logic              lvl_a,
  input  logic              lvl_b,
  input  logic [DATA_W-1:0] cmp_a,
  input  logic [DATA_W-1:0] cmp_b,
  output logic [DATA_W-1:0] cnt,
  output logic              out_lvl,
  output logic              period_hit
);
  logic [DATA_W-1:0] cnt_q, cnt_d;
  logic              out_q, out_d;
  logic              edge_hit;

  assign period_hit = step & pwm_on & (cnt_q == cmp_b);
  assign edge_hit   = step & pwm_on & (cnt_q == cmp_a);

  always_comb begin
    cnt_d = cnt_q;
    if (period_hit)  cnt_d = RELOAD;
    else if (step)   cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    out_d = out_q;
    if (period_hit)    out_d = lvl_b;
    else if (edge_hit) out_d = lvl_a;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RELOAD;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign cnt     = cnt_q;
  assign out_lvl = out_q;

  // R2: no step, no counter change
  p_cnt_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt_q));

  // R4: a step on the period value reloads the start value
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && pwm_on && (cnt_q == cmp_b)) |=> (cnt_q == RELOAD));

  // R10: outside PWM mode every step is a plain increment
  p_free_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !pwm_on) |=> (cnt_q == DATA_W'($past(cnt_q) + 1'b1)));

  // R10: outside PWM mode the output level holds
  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_on |=> $stable(out_q));
endmodule

// File: rtl/pwmt_regs.sv
module pwmt_regs
  import pwmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] cnt,
  input  logic              period_hit,
  output cfg_t              cfg,
  output logic [DATA_W-1:0] cmp_a,
  output logic [DATA_W-1:0] cmp_b,
  output logic              flag,
  output logic              sel_chg
);
  cfg_t              cfg_q, cfg_d;
  logic [DATA_W-1:0] cmpa_q, cmpa_d, cmpb_q, cmpb_d;
  logic              flag_q, flag_d, arm_q, arm_d;
  logic              wr_cfg, rd_stat, rd_clr;
  cfg_t              wcfg;

  assign wcfg    = cfg_t'(wdata);
  assign wr_cfg  = wr_en & (addr == A_CFG);
  assign sel_chg = wr_cfg & (wcfg.clk_sel != cfg_q.clk_sel);
  assign rd_stat = rd_en & (addr == A_STAT);
  assign rd_clr  = rd_en & (addr == A_CLR);

  always_comb begin
    cfg_d  = cfg_q;
    cmpa_d = cmpa_q;
    cmpb_d = cmpb_q;
    if (wr_cfg)                       cfg_d  = wcfg;
    if (wr_en && (addr == A_CMPA))    cmpa_d = wdata;
    if (wr_en && (addr == A_CMPB))    cmpb_d = wdata;
  end

  always_comb begin
    arm_d = arm_q;
    if (rd_stat && flag_q) arm_d = 1'b1;
    else if (rd_clr)       arm_d = 1'b0;
    flag_d = flag_q;
    if (period_hit)            flag_d = 1'b1;
    else if (rd_clr && arm_q)  flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      cmpa_q <= cmpa_d;
      cmpb_q <= cmpb_d;
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  always_comb begin
    unique case (addr)
      A_CFG:        rdata = DATA_W'(cfg_q);
      A_CMPA:       rdata = cmpa_q;
      A_CMPB:       rdata = cmpb_q;
      A_STAT:       rdata = {{(DATA_W-1){1'b0}}, flag_q};
      A_CLR, A_CNT: rdata = cnt;
      default:      rdata = '0;
    endcase
  end

  assign cfg   = cfg_q;
  assign cmp_a = cmpa_q;
  assign cmp_b = cmpb_q;
  assign flag  = flag_q;

  // R8: the flag only rises after a period match
  p_flag_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(period_hit));

  // R9: a match during the clearing read keeps the flag
  p_match_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (period_hit && rd_clr) |=> flag_q);

  // R9: the flag only falls through an armed clearing read
  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(rd_clr && arm_q));
endmodule

// File: rtl/pwm_dual_timer.sv
module pwm_dual_timer
  import pwmt_pkg::*;
#(
  parameter int                DIV0   = 2,
  parameter int                DIV1   = 4,
  parameter int                DIV2   = 8,
  parameter int                DIV3   = 8000,
  parameter logic [7:0]        RELOAD = 8'hFC
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       pwm_out,
  output logic       irq
);
  logic [1:0]        rs_q;
  logic              srst_n;
  cfg_t              cfg;
  logic [DATA_W-1:0] cmp_a, cmp_b, cnt;
  logic              flag, sel_chg, step, out_lvl, period_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  pwmt_regs u_regs (
    .clk        (clk),
    .rst_n      (srst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .cnt        (cnt),
    .period_hit (period_hit),
    .cfg        (cfg),
    .cmp_a      (cmp_a),
    .cmp_b      (cmp_b),
    .flag       (flag),
    .sel_chg    (sel_chg)
  );

  pwmt_prescaler #(
    .DIV0 (DIV0), .DIV1 (DIV1), .DIV2 (DIV2), .DIV3 (DIV3)
  ) u_pre (
    .clk     (clk),
    .rst_n   (srst_n),
    .tick_en (tick_en),
    .sel     (cfg.clk_sel),
    .restart (sel_chg),
    .step    (step)
  );

  pwmt_core #(.RELOAD (RELOAD)) u_core (
    .clk        (clk),
    .rst_n      (srst_n),
    .step       (step),
    .pwm_on     (cfg.pwm_on),
    .lvl_a      (cfg.lvl_a),
    .lvl_b      (cfg.lvl_b),
    .cmp_a      (cmp_a),
    .cmp_b      (cmp_b),
    .cnt        (cnt),
    .out_lvl    (out_lvl),
    .period_hit (period_hit)
  );

  assign pwm_out = cfg.out_en & out_lvl;
  assign irq     = flag & cfg.irq_en & ~cfg.irq_mask;

  // R7: the pin is quiet while the output is disabled
  p_pin_off_r7: assert property (@(posedge clk) disable iff (!srst_n)
    !cfg.out_en |-> !pwm_out);
endmodule

// File: tb/pwm_dual_timer_test.sv
module pwm_dual_timer_test;
  logic       clk = 1'b0;
  logic       rst_n, tick_en, wr_en, rd_en;
  logic [2:0] addr;
  logic [7:0] wdata, rdata;
  logic       pwm_out, irq;
  int         checks = 0;
  int         fails  = 0;
  bit         done   = 1'b0;

  always #10 clk = ~clk;

  pwm_dual_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out), .irq(irq)
  );

  function automatic int div_of(int sel);
    case (sel)
      0: return 2;
      1: return 4;
      2: return 8;
      default: return 8000;
    endcase
  endfunction

  function automatic int exp_period(int b, int sel);
    return (b + 5) * div_of(sel);
  endfunction

  function automatic int exp_width(int a, int b, int sel);
    return (b - a) * div_of(sel);
  endfunction

  function automatic logic [7:0] cfgv(int sel, int oe, int pw, int mk, int en, int lb, int la);
    return {2'(sel), 1'(oe), 1'(pw), 1'(mk), 1'(en), 1'(lb), 1'(la)};
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic tick_pair();
    for (int i = 0; i < 2; i++) begin
      tick_en = 1'b1; @(negedge clk);
      tick_en = 1'b0; @(negedge clk);
    end
  endtask

  task automatic measure(output int hi, output int per);
    int g; logic prev;
    hi = 0; g = 0; prev = pwm_out;
    while (!(pwm_out && !prev) && g < 20000) begin prev = pwm_out; @(negedge clk); g++; end
    while (pwm_out && g < 20000) begin hi++; @(negedge clk); g++; end
    per = hi;
    while (!pwm_out && g < 20000) begin per++; @(negedge clk); g++; end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v, c0;
    int hi, per, a, b, s, toggles;
    logic first;
    void'($urandom(32'd4711));
    rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    peek(3'd5, v); chk("R1 count", v, 8'hFC);
    for (int i = 0; i < 4; i++) begin peek(3'(i), v); chk("R1 reg zero", v, 0); end
    chk("R1 pwm_out", pwm_out, 0);
    chk("R1 irq", irq, 0);
    wr(3'd1, 8'h5A); peek(3'd1, v); chk("R1 readback edge cmp", v, 8'h5A);
    wr(3'd2, 8'hA5); peek(3'd2, v); chk("R1 readback period cmp", v, 8'hA5);

    // R2 / R3 divider per clock select, PWM off, ticks continuous
    tick_en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      s = (k + 1) % 4;
      wr(3'd0, cfgv(s, 0, 0, 0, 0, 0, 0));
      peek(3'd5, c0);
      repeat (div_of(s) - 1) @(negedge clk);
      peek(3'd5, v); chk("R2 no step before divide", v, c0);
      @(negedge clk);
      peek(3'd5, v); chk("R2 step at divide", v, 8'(c0 + 1));
    end

    // R3 restart on select change mid-count
    wr(3'd0, cfgv(2, 0, 0, 0, 0, 0, 0));
    repeat (5) @(negedge clk);
    wr(3'd0, cfgv(1, 0, 0, 0, 0, 0, 0));
    peek(3'd5, c0);
    repeat (3) @(negedge clk);
    peek(3'd5, v); chk("R3 restarted no early step", v, c0);
    @(negedge clk);
    peek(3'd5, v); chk("R3 restarted step", v, 8'(c0 + 1));

    // R2 freeze with tick_en low
    tick_en = 1'b0;
    peek(3'd5, c0);
    repeat (50) @(negedge clk);
    peek(3'd5, v); chk("R2 frozen without tick", v, c0);
    tick_en = 1'b1;

    // R10 free run wrap, no reload, no flag
    wr(3'd2, 8'h10);
    wr(3'd0, cfgv(0, 1, 0, 0, 0, 0, 0));
    peek(3'd5, c0);
    repeat (600) @(negedge clk);
    peek(3'd5, v); chk("R10 free run wraps", v, 8'(c0 + 300));
    peek(3'd3, v); chk("R10 no flag", v, 0);

    // R4 / R5 directed
    wr(3'd1, 8'h10); wr(3'd2, 8'h30);
    wr(3'd0, cfgv(0, 1, 1, 0, 0, 0, 1));
    measure(hi, per); measure(hi, per);
    chk("R5 high width", hi, exp_width(16, 48, 0));
    chk("R4 period", per, exp_period(48, 0));

    // R5 swapped levels
    wr(3'd0, cfgv(0, 1, 1, 0, 0, 1, 0));
    measure(hi, per); measure(hi, per);
    chk("R5 swapped low width", per - hi, exp_width(16, 48, 0));
    chk("R4 period swapped", per, exp_period(48, 0));

    // R4 / R5 random
    for (int it = 0; it < 8; it++) begin
      b = 10 + int'($urandom_range(50));
      a = 1 + int'($urandom_range(b - 2));
      s = int'($urandom_range(2));
      wr(3'd0, cfgv(s, 1, 0, 0, 0, 0, 1));
      wr(3'd1, 8'(a)); wr(3'd2, 8'(b));
      wr(3'd0, cfgv(s, 1, 1, 0, 0, 0, 1));
      measure(hi, per); measure(hi, per);
      chk("R5 random high width", hi, exp_width(a, b, s));
      chk("R4 random period", per, exp_period(b, s));
    end

    // R6 equal levels
    wr(3'd1, 8'h10); wr(3'd2, 8'h30);
    for (int lv = 0; lv < 2; lv++) begin
      wr(3'd0, cfgv(0, 1, 1, 0, 0, lv, lv));
      repeat (250) @(negedge clk);
      toggles = 0; first = pwm_out;
      repeat (300) begin @(negedge clk); if (pwm_out != first) toggles++; end
      chk("R6 constant output", toggles, 0);
      chk("R6 level", pwm_out, lv);
    end

    // R7 output disabled
    wr(3'd0, cfgv(0, 0, 1, 0, 0, 0, 1));
    toggles = 0;
    repeat (300) begin @(negedge clk); if (pwm_out) toggles++; end
    chk("R7 pin low while disabled", toggles, 0);

    // R8 flag and irq gating
    wr(3'd0, cfgv(0, 1, 1, 0, 1, 0, 1));
    repeat (250) @(negedge clk);
    wr(3'd0, cfgv(0, 1, 0, 0, 1, 0, 1));
    peek(3'd3, v); chk("R8 flag set", v, 1);
    chk("R8 irq enabled", irq, 1);
    wr(3'd0, cfgv(0, 1, 0, 1, 1, 0, 1)); chk("R8 irq masked", irq, 0);
    wr(3'd0, cfgv(0, 1, 0, 0, 0, 0, 1)); chk("R8 irq disabled", irq, 0);
    wr(3'd0, cfgv(0, 1, 0, 0, 1, 0, 1)); chk("R8 irq back", irq, 1);

    // R9 clear sequence
    rd(3'd4, v);
    peek(3'd3, v); chk("R9 unarmed read keeps flag", v, 1);
    rd(3'd3, v); rd(3'd4, v);
    peek(3'd3, v); chk("R9 armed read clears", v, 0);
    chk("R9 irq after clear", irq, 0);

    // R10 output hold with PWM off
    wr(3'd0, cfgv(0, 1, 1, 0, 0, 1, 1));
    repeat (250) @(negedge clk);
    rd(3'd3, v); rd(3'd4, v);
    wr(3'd0, cfgv(0, 1, 0, 0, 0, 0, 0));
    toggles = 0;
    repeat (600) begin @(negedge clk); if (!pwm_out) toggles++; end
    chk("R10 output holds high", toggles, 0);
    peek(3'd3, v); chk("R10 no flag when off", v, 0);

    // R9 period match colliding with clearing read
    tick_en = 1'b0;
    wr(3'd1, 8'h08); wr(3'd2, 8'h20);
    wr(3'd0, cfgv(1, 1, 1, 0, 0, 0, 1));
    wr(3'd0, cfgv(0, 1, 1, 0, 0, 0, 1));
    peek(3'd5, v);
    while (v != 8'h20) begin tick_pair(); peek(3'd5, v); end
    tick_pair();
    peek(3'd5, v); chk("R4 manual reload", v, 8'hFC);
    peek(3'd3, v); chk("R8 manual flag", v, 1);
    rd(3'd3, v);
    peek(3'd5, v);
    while (v != 8'h20) begin tick_pair(); peek(3'd5, v); end
    tick_en = 1'b1; @(negedge clk); tick_en = 1'b0; @(negedge clk);
    tick_en = 1'b1; addr = 3'd4; rd_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0; rd_en = 1'b0;
    peek(3'd3, v); chk("R9 match beats clear", v, 1);
    peek(3'd5, v); chk("R4 reload at collision", v, 8'hFC);
    rd(3'd3, v); rd(3'd4, v);
    peek(3'd3, v); chk("R9 clear after collision", v, 0);

    summary();
    $finish;
  end
endmodule